// File: doc/BRIEF.md
# Open-Load Monitor with Fault Flag

This block watches the sixteen current-sink channels of an LED driver. For each channel it finds loads that are open or missing, and it folds those results together with an over-temperature indication into one active-low fault line. The comparators and the temperature sensor sit outside the block, in analog logic, and reach it as digital inputs. One bit per channel reports that the output pin is below the detect threshold, and one bit reports that the die is too hot. The sensor applies its own hysteresis before that bit clears.

Each channel is driven only when three things hold: its latched on bit is set, the active-low output enable is low, and the die is not hot. Channel outputs switch on in a staggered order, so channel i starts `i*STAGGER_CYC` clocks after it is enabled. Each driven channel is sampled once, `SAMPLE_CYC` clocks after its own stagger delay has run out. The result waits in a per-channel holding bit. On the next latch pulse the holding word is copied into `status_word`, where the serial block picks it up, and the holding word is then cleared for the new interval.

A latch pulse that comes too soon after the one before it sets a sticky flag, because the status it would read out is not valid. The flag stays set until reset.

Top module: `open_load_monitor`

## Requirements
- R1: Let channel i be enabled (on bit set, `oe_n` low, `hot` low) continuously from posedge E0 onward, after having been disabled. Then `drive_on[i]` is 1 after posedge En exactly when n+1 >= i*STAGGER_CYC. A channel that stays enabled across a latch pulse stays driven. `drive_on[i]` drops in the same cycle in which the enable goes away.
- R2: A holding bit takes the value of `cmp_low[i]` only on the single edge at which its driven channel has been on for `SAMPLE_CYC` clocks after its stagger delay. A channel that is still enabled when a latch pulse arrives is sampled again after another `SAMPLE_CYC` clocks.
- R3: On a clock edge with `le_pulse` high, `status_word` takes the holding word and the holding word clears. So the word that appears after latch k reports the interval between latch k-1 and latch k. Bit i belongs to channel i.
- R4: A channel that is off, or that was masked by `oe_n` high for the whole interval, reports 0 in `status_word`, whatever its `cmp_low` bit was.
- R5: `fault_n` is registered. It is 0 after an edge at which `hot` was 1, or at which some driven channel had `cmp_low` at 1. Otherwise it is 1. When `oe_n` is high, the open-load part of the fault is masked.
- R6: While `hot` is 1, every `drive_on` bit is 0. Once `hot` clears, the enabled channels restart their staggered turn-on from zero.
- R7: The holding word is not changed while its channels are disabled. Status that was sampled before an over-temperature event is delivered by the next latch pulse even if that pulse comes during the event.
- R8: A latch pulse that arrives fewer than `SPACING_CYC` clocks after the one before it sets `latch_early`, which stays at 1 until reset. A spacing of exactly `SPACING_CYC` clocks does not set it, and neither does the first latch pulse after reset.
- R9: After reset, `status_word` is 0, `fault_n` is 1 and `latch_early` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| le_pulse | input | 1 | One-cycle latch event from the serial block |
| oe_n | input | 1 | Active-low output enable for all channels |
| onoff | input | NCH | Latched per-channel on bits |
| cmp_low | input | NCH | Per-channel comparator: output below detect threshold |
| hot | input | 1 | Over-temperature indication (hysteretic) |
| drive_on | output | NCH | Staggered per-channel drive command |
| status_word | output | NCH | Open-load word for the serial block, bit i = channel i |
| fault_n | output | 1 | Active-low combined fault flag |
| latch_early | output | 1 | Sticky flag for latch pulses that are spaced too closely |

## Verification
The bench counts positions in clocks after the latch edge E0. Inputs change at the negedge before E0, and each check is made at the negedge after the edge it examines. A channel's drive command is due after edge E(i*STAGGER_CYC-1), which means n+1 >= i*STAGGER_CYC. The status word is due one negedge after the latch edge and carries the previous interval. `fault_n` and `latch_early` are due one negedge after the edge that caused them. The fault line is checked late in each interval, once every channel is driven. Intervals are exactly `SPACING_CYC` clocks long, apart from one that is a clock short, which is how the spacing boundary is checked from both sides.

// File: rtl/olm_pkg.sv
// Package: shared helpers for the open-load monitor.
// Assumes: indices and cycle counts are small non-negative integers.
package olm_pkg;

    // Clock count at which a channel's stagger delay ends.
    function automatic int unsigned stagger_tap(input int unsigned idx, input int unsigned stg);
        return idx * stg;
    endfunction

    // Clock count at which a channel's comparator is sampled.
    function automatic int unsigned sample_tap(input int unsigned idx, input int unsigned stg,
                                               input int unsigned samp);
        return idx * stg + samp;
    endfunction

endpackage

// File: rtl/olm_channel.sv
// Module: one channel of open-load detection.
// Counts clocks while the channel is enabled, raises the drive command once
// the channel's stagger delay has passed, samples the comparator once at the
// sample tap into a holding bit, and hands that bit to the status bit on a
// latch pulse.
// Assumes: en already combines on bit, output enable and temperature;
// CW is wide enough to hold sample_tap(IDX)+1.
module olm_channel
    import olm_pkg::*;
#(
    parameter int unsigned IDX  = 0,
    parameter int unsigned STG  = 5,
    parameter int unsigned SAMP = 50,
    parameter int unsigned CW   = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic cmp_low,
    input  logic le_pulse,
    output logic drive,
    output logic held,
    output logic status_bit
);

    localparam int unsigned KT = stagger_tap(IDX, STG);
    localparam int unsigned TT = sample_tap(IDX, STG, SAMP);

    logic [CW-1:0] cnt;

    // On-time counter: clears when disabled, pulls back to the stagger tap on a latch, saturates past the sample tap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en) begin
            cnt <= '0;
        end else if (le_pulse && (cnt >= CW'(KT))) begin
            cnt <= CW'(KT);
        end else if (cnt <= CW'(TT)) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Drive command: enabled and stagger delay served.
    always_comb begin
        drive = en && (cnt >= CW'(KT));
    end

    // Holding bit: cleared by a latch, loaded once at the sample tap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= 1'b0;
        end else if (le_pulse) begin
            held <= 1'b0;
        end else if (en && (cnt == CW'(TT))) begin
            held <= cmp_low;
        end
    end

    // Status bit: takes the holding bit on each latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_bit <= 1'b0;
        end else if (le_pulse) begin
            status_bit <= held;
        end
    end

    p_take_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        le_pulse |=> (status_bit == $past(held)));

    p_hold_cleared_r3: assert property (@(posedge clk) disable iff (!rst_n)
        le_pulse |=> !held);

    p_idle_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !le_pulse) |=> $stable(held));

    p_flag_needs_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(held) |-> ($past(drive) && $past(cmp_low)));

endmodule

// File: rtl/olm_spacing.sv
// Module: minimum spacing monitor for latch pulses.
// Counts clocks since the last latch pulse, saturating at SPACING. A pulse
// that arrives before the count reaches SPACING sets a sticky flag.
// Assumes: le_pulse is a single-cycle event; SPACING >= 1.
module olm_spacing #(
    parameter int unsigned SPACING = 415
) (
    input  logic clk,
    input  logic rst_n,
    input  logic le_pulse,
    output logic early
);

    localparam int unsigned GW = $clog2(SPACING + 1);

    logic [GW-1:0] gap;

    // Gap counter: starts saturated so the first pulse after reset is legal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap <= GW'(SPACING);
        end else if (le_pulse) begin
            gap <= GW'(1);
        end else if (gap < GW'(SPACING)) begin
            gap <= gap + 1'b1;
        end
    end

    // Sticky violation flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            early <= 1'b0;
        end else if (le_pulse && (gap < GW'(SPACING))) begin
            early <= 1'b1;
        end
    end

    p_early_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        early |=> early);

    p_early_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(early) |-> $past(le_pulse));

endmodule

// File: rtl/olm_fault.sv
// Module: combined active-low fault register.
// Pulls the flag low on over-temperature or on any driven channel whose
// comparator reports a low output voltage.
// Assumes: drive is already masked by output enable and temperature.
module olm_fault #(
    parameter int unsigned NCH = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] drive,
    input  logic [NCH-1:0] cmp_low,
    input  logic           hot,
    output logic           fault_n
);

    logic open_any;

    // Live open-load condition over all driven channels.
    always_comb begin
        open_any = |(drive & cmp_low);
    end

    // Fault register, released high after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_n <= 1'b1;
        end else begin
            fault_n <= !(hot || open_any);
        end
    end

    p_hot_pulls_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hot |=> !fault_n);

    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!hot && (cmp_low == '0)) |=> fault_n);

endmodule

// File: rtl/open_load_monitor.sv
// Module: top of the open-load monitor.
// Gates each channel's on bit with output enable and temperature, builds one
// detection channel per output, and adds the fault register and the latch
// spacing monitor.
// Assumes: le_pulse is one clock wide and coincides with the edge at which the
// serial block updates onoff.
module open_load_monitor
    import olm_pkg::*;
#(
    parameter int unsigned NCH         = 16,
    parameter int unsigned STAGGER_CYC = 5,
    parameter int unsigned SAMPLE_CYC  = 50,
    parameter int unsigned SPACING_CYC = 415
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           le_pulse,
    input  logic           oe_n,
    input  logic [NCH-1:0] onoff,
    input  logic [NCH-1:0] cmp_low,
    input  logic           hot,
    output logic [NCH-1:0] drive_on,
    output logic [NCH-1:0] status_word,
    output logic           fault_n,
    output logic           latch_early
);

    localparam int unsigned TMAX = sample_tap(NCH - 1, STAGGER_CYC, SAMPLE_CYC);
    localparam int unsigned CW   = $clog2(TMAX + 2);

    logic [NCH-1:0] ch_en;
    logic [NCH-1:0] held_word;

    // Channel enable: on bit, output enable low, die not hot.
    always_comb begin
        ch_en = onoff & {NCH{!oe_n && !hot}};
    end

    for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
        olm_channel #(
            .IDX  (gi),
            .STG  (STAGGER_CYC),
            .SAMP (SAMPLE_CYC),
            .CW   (CW)
        ) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .en         (ch_en[gi]),
            .cmp_low    (cmp_low[gi]),
            .le_pulse   (le_pulse),
            .drive      (drive_on[gi]),
            .held       (held_word[gi]),
            .status_bit (status_word[gi])
        );
    end

    olm_fault #(
        .NCH (NCH)
    ) u_fault (
        .clk     (clk),
        .rst_n   (rst_n),
        .drive   (drive_on),
        .cmp_low (cmp_low),
        .hot     (hot),
        .fault_n (fault_n)
    );

    olm_spacing #(
        .SPACING (SPACING_CYC)
    ) u_spacing (
        .clk      (clk),
        .rst_n    (rst_n),
        .le_pulse (le_pulse),
        .early    (latch_early)
    );

    p_hot_dark_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hot |=> (drive_on == '0 || !$past(hot) || $fell(hot)));

    if (STAGGER_CYC > 0 && NCH > 2) begin : g_restagger
        p_restagger_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(hot) |=> !drive_on[NCH-1]);
    end

endmodule

// File: tb/open_load_monitor_tb.sv
module open_load_monitor_tb;

    localparam int NCH  = 16;
    localparam int STG  = 2;
    localparam int SAMP = 6;
    localparam int SP   = 48;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           le_pulse = 1'b0;
    logic           oe_n = 1'b1;
    logic [NCH-1:0] onoff = '0;
    logic [NCH-1:0] cmp_low = '0;
    logic           hot = 1'b0;
    logic [NCH-1:0] drive_on;
    logic [NCH-1:0] status_word;
    logic           fault_n;
    logic           latch_early;

    int n_chk = 0;
    int n_fail = 0;
    logic [NCH-1:0] exp_hold = '0;
    logic [NCH-1:0] prev_full = '0;
    logic           exp_early = 1'b0;
    logic [31:0]    seed = 32'h1234_5678;

    always #2 clk = ~clk;

    open_load_monitor #(
        .NCH         (NCH),
        .STAGGER_CYC (STG),
        .SAMPLE_CYC  (SAMP),
        .SPACING_CYC (SP)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .le_pulse    (le_pulse),
        .oe_n        (oe_n),
        .onoff       (onoff),
        .cmp_low     (cmp_low),
        .hot         (hot),
        .drive_on    (drive_on),
        .status_word (status_word),
        .fault_n     (fault_n),
        .latch_early (latch_early)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] next_rnd(input logic [31:0] s);
        logic [31:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    // Latch edge E0 happens inside; returns at the negedge after E0 (n=0).
    task automatic do_latch(input logic [NCH-1:0] on, input logic [NCH-1:0] c);
        logic [NCH-1:0] exp_status;
        onoff    = on;
        cmp_low  = c;
        le_pulse = 1'b1;
        @(negedge clk);
        le_pulse = 1'b0;
        exp_status = exp_hold;
        chk(32'(status_word), 32'(exp_status), "R3 status word after latch");
        chk(32'(latch_early), 32'(exp_early), "R8 spacing flag");
        exp_hold = (oe_n || hot) ? '0 : (on & c);
    endtask

    // Runs to the negedge before E_d, checking stagger (R1) and fault (R5).
    task automatic run_interval(input int d);
        for (int n = 0; n <= d - 2; n++) begin
            logic [NCH-1:0] exp_drv;
            for (int i = 0; i < NCH; i++) begin
                exp_drv[i] = onoff[i] && !oe_n && !hot &&
                             (prev_full[i] || ((n + 1) >= i * STG));
            end
            chk(32'(drive_on), 32'(exp_drv), "R1 staggered drive");
            if (n == d - 2) begin
                chk(32'(fault_n), 32'(oe_n || !(|(onoff & cmp_low))), "R5 fault line");
            end
            @(negedge clk);
        end
        prev_full = oe_n ? '0 : onoff;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(32'(status_word), 32'h0, "R9 reset status");
        chk(32'(fault_n), 32'h1, "R9 reset fault");
        chk(32'(latch_early), 32'h0, "R9 reset spacing flag");
        chk(32'(drive_on), 32'h0, "R9 reset drive");

        oe_n = 1'b0;
        do_latch(16'hFFFF, 16'hA5C3);
        run_interval(SP);

        for (int k = 0; k < 20; k++) begin
            logic [NCH-1:0] on_p;
            logic [NCH-1:0] c_p;
            seed = next_rnd(seed);
            on_p = seed[NCH-1:0];
            c_p  = seed[31:32-NCH];
            do_latch(on_p, c_p);
            run_interval(SP);
        end

        // R4: channels off report 0 although the comparator is low.
        do_latch(16'h0000, 16'hFFFF);
        run_interval(SP);
        do_latch(16'hFFFF, 16'hFFFF);
        chk(32'(status_word), 32'h0, "R4 off channels report zero");
        run_interval(SP);

        // R4/R5: output enable high masks drive, status and fault.
        oe_n = 1'b1;
        do_latch(16'hFFFF, 16'hFFFF);
        run_interval(SP);
        oe_n = 1'b0;
        do_latch(16'h00FF, 16'h0F0F);
        chk(32'(status_word), 32'h0, "R4 masked interval reports zero");
        run_interval(SP);

        // R6/R7: over-temperature after sampling, latch during the event.
        do_latch(16'hFFFF, 16'h0F0F);
        repeat (40) @(negedge clk);
        hot = 1'b1;
        @(negedge clk);
        chk(32'(fault_n), 32'h0, "R5 fault on over-temperature");
        chk(32'(drive_on), 32'h0, "R6 outputs off while hot");
        repeat (SP) @(negedge clk);
        do_latch(16'hFFFF, 16'hFFFF);
        chk(32'(status_word), 32'h0F0F, "R7 status kept through over-temperature");
        for (int n = 0; n < SP - 1; n++) begin
            chk(32'(drive_on), 32'h0, "R6 outputs off while hot");
            chk(32'(fault_n), 32'h0, "R5 fault held while hot");
            @(negedge clk);
        end
        hot = 1'b0;
        prev_full = '0;
        do_latch(16'hFFFF, 16'h3333);
        chk(32'(status_word), 32'h0, "R7 nothing sampled while hot");
        run_interval(SP);

        // R8: exact spacing was legal throughout; one short interval sets the flag.
        do_latch(16'h5555, 16'h00F0);
        run_interval(SP - 1);
        exp_early = 1'b1;
        do_latch(16'hAAAA, 16'h0FF0);
        run_interval(SP);
        do_latch(16'hFFFF, 16'h0000);
        chk(32'(latch_early), 32'h1, "R8 spacing flag sticky");
        run_interval(SP);
        do_latch(16'h0000, 16'h0000);
        chk(32'(status_word), 32'h0, "R2 no comparator low, no flags");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule